// File: doc/BRIEF.md
# CCD Horizontal Readout Timing Generator

This block produces the logic-level drive pattern for the horizontal output register of a frame-transfer area sensor, one line at a time. A master clock at four times the pixel rate (100 MHz for a 25 MHz pixel rate) advances a quarter-phase counter and a pixel counter. The pixel counter covers a fixed line of 2040 pixel periods. From these counters the block derives four quarter-shifted register clocks and a reset-gate pulse. It also produces a region tag and an in-region pixel index, which a downstream sampler uses to tell dummy, black, overscan, in-aspect active and blanking periods apart.

During readout the line contains 1696 register cells. The blanking periods that follow are held quiet: the register clocks are parked and the reset gate is idle, so a vertical sequencer can place its line shifts there. The vertical sequencer keys off the blanking window and a line-start strobe. Deasserting the enable input parks every output and rewinds the line.

Top module: `ccd_hreadout_tg`

## Requirements
- R1: While rst_ni is low, and while en_i is low, the outputs are idle: hclk_o=4'b0011, rg_o=0, zone_o=0, idx_o=0, blank_o=1, line_start_o=0.
- R2: When enabled, a line lasts 2040 pixel periods of 4 master cycles each, so successive line_start_o pulses are 8160 master cycles apart.
- R3: Each line has a fixed order of zones, with these lengths in pixel periods and zone_o codes:
  - dummy: 8 periods, code 1
  - black: 2 periods, code 2
  - overscan: 8 periods, code 3
  - active (in-aspect): 1600 periods, code 4
  - overscan: 8 periods, code 3
  - black: 70 periods, code 2
  - blanking: 344 periods, code 0
- R4: idx_o counts pixel periods from 0 within each contiguous zone segment. It restarts at 0 at every zone boundary.
- R5: Outside blanking, hclk_o bit k (bit 0 = first phase) is high in quarters k and (k+1) mod 4 of each pixel period. Each phase therefore has a 50% duty cycle and lags the previous phase by one quarter.
- R6: During blanking, hclk_o holds the static pattern 4'b0011: phases 1 and 2 are high, phases 3 and 4 are low.
- R7: rg_o is high for exactly one master cycle, in quarter 0 of every non-blanking pixel period. It is never high during blanking.
- R8: line_start_o is high for one master cycle, in quarter 0 of pixel 0 of every line, including the first line after enable. Quarter 0 of pixel 0 is presented on the first enabled clock edge.
- R9: blank_o is high exactly when zone_o is the blanking code.
- R10: Dropping en_i mid-line returns all outputs to the idle state of R1 on the next edge. Re-enabling restarts at quarter 0 of pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, four times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low parks and rewinds the line |
| hclk_o | output | 4 | Horizontal register phase clocks, bit 0 = phase 1 |
| rg_o | output | 1 | Reset-gate pulse |
| zone_o | output | 3 | Region tag of the current pixel period |
| idx_o | output | 11 | Pixel index within the current zone segment |
| blank_o | output | 1 | Line-blanking window |
| line_start_o | output | 1 | One-cycle strobe at the start of each line |

## Verification
A wrong quarter counter shows up within one master cycle: a register phase or the reset-gate pulse lands in the wrong quarter. A pixel counter that slips or wraps at the wrong count is first visible as an idx_o value that is off by one. It then shows as a zone boundary arriving early or late, at the latest at the next zone edge, which is at most 1600 pixel periods away. The line length itself is confirmed at the next line_start_o. A fault in the enable path shows on the first edge after en_i changes, as outputs that fail to park or a line that does not restart at pixel 0.

// File: rtl/ccd_hrt_pkg.sv
package ccd_hrt_pkg;
  typedef enum logic [2:0] {
    ZN_BLANK  = 3'd0,
    ZN_DUMMY  = 3'd1,
    ZN_BLACK  = 3'd2,
    ZN_OVSCAN = 3'd3,
    ZN_ACTIVE = 3'd4
  } zone_e;

  localparam logic [3:0] CLK_IDLE = 4'b0011;
endpackage

// File: rtl/hrt_phase_cnt.sv
module hrt_phase_cnt #(
  parameter int LINE_LEN = 2040,
  parameter int PIX_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [1:0]       qtr_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(LINE_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qtr_o <= '0;
      pix_o <= '0;
    end else if (!en_i) begin
      qtr_o <= '0;
      pix_o <= '0;
    end else begin
      qtr_o <= qtr_o + 2'd1;
      if (qtr_o == 2'd3)
        pix_o <= (pix_o == LAST_PIX) ? '0 : pix_o + 1'b1;
    end
  end

  // R2
  pix_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_o <= LAST_PIX);
  // R2
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && qtr_o != 2'd0) |-> $stable(pix_o));
endmodule

// File: rtl/hrt_zone_dec.sv
module hrt_zone_dec
  import ccd_hrt_pkg::*;
#(
  parameter int N_DUMMY = 8,
  parameter int N_BLK_L = 2,
  parameter int N_OVS   = 8,
  parameter int N_ACT   = 1600,
  parameter int N_BLK_R = 70,
  parameter int PIX_W   = 11
) (
  input  logic [PIX_W-1:0] pix_i,
  output zone_e            zone_o,
  output logic [PIX_W-1:0] idx_o
);
  // segment start positions along the line
  localparam int S_BLK_L = N_DUMMY;
  localparam int S_OVS_L = S_BLK_L + N_BLK_L;
  localparam int S_ACT   = S_OVS_L + N_OVS;
  localparam int S_OVS_R = S_ACT + N_ACT;
  localparam int S_BLK_R = S_OVS_R + N_OVS;
  localparam int S_BLANK = S_BLK_R + N_BLK_R;

  localparam logic [PIX_W-1:0] B_BLK_L = PIX_W'(S_BLK_L);
  localparam logic [PIX_W-1:0] B_OVS_L = PIX_W'(S_OVS_L);
  localparam logic [PIX_W-1:0] B_ACT   = PIX_W'(S_ACT);
  localparam logic [PIX_W-1:0] B_OVS_R = PIX_W'(S_OVS_R);
  localparam logic [PIX_W-1:0] B_BLK_R = PIX_W'(S_BLK_R);
  localparam logic [PIX_W-1:0] B_BLANK = PIX_W'(S_BLANK);

  always_comb begin
    if (pix_i >= B_BLANK) begin
      zone_o = ZN_BLANK;
      idx_o  = pix_i - B_BLANK;
    end else if (pix_i >= B_BLK_R) begin
      zone_o = ZN_BLACK;
      idx_o  = pix_i - B_BLK_R;
    end else if (pix_i >= B_OVS_R) begin
      zone_o = ZN_OVSCAN;
      idx_o  = pix_i - B_OVS_R;
    end else if (pix_i >= B_ACT) begin
      zone_o = ZN_ACTIVE;
      idx_o  = pix_i - B_ACT;
    end else if (pix_i >= B_OVS_L) begin
      zone_o = ZN_OVSCAN;
      idx_o  = pix_i - B_OVS_L;
    end else if (pix_i >= B_BLK_L) begin
      zone_o = ZN_BLACK;
      idx_o  = pix_i - B_BLK_L;
    end else begin
      zone_o = ZN_DUMMY;
      idx_o  = pix_i;
    end
  end
endmodule

// File: rtl/hrt_clk_gen.sv
module hrt_clk_gen
  import ccd_hrt_pkg::*;
#(
  parameter int N_PH   = 4,
  parameter int RG_QTR = 0
) (
  input  logic [1:0]      qtr_i,
  input  logic            readout_i,
  output logic [N_PH-1:0] hclk_o,
  output logic            rg_o
);
  // each phase is high for two consecutive quarters, one quarter after its predecessor
  for (genvar k = 0; k < N_PH; k++) begin : g_ph
    assign hclk_o[k] = readout_i ? ((qtr_i == 2'(k)) || (qtr_i == 2'((k + 1) % N_PH)))
                                 : CLK_IDLE[k];
  end

  assign rg_o = readout_i && (qtr_i == 2'(RG_QTR));
endmodule

// File: rtl/ccd_hreadout_tg.sv
module ccd_hreadout_tg
  import ccd_hrt_pkg::*;
#(
  parameter int N_DUMMY  = 8,
  parameter int N_BLK_L  = 2,
  parameter int N_OVS    = 8,
  parameter int N_ACT    = 1600,
  parameter int N_BLK_R  = 70,
  parameter int LINE_LEN = 2040,
  localparam int PIX_W   = $clog2(LINE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [3:0]       hclk_o,
  output logic             rg_o,
  output logic [2:0]       zone_o,
  output logic [PIX_W-1:0] idx_o,
  output logic             blank_o,
  output logic             line_start_o
);
  logic [1:0]       qtr;
  logic [PIX_W-1:0] pix;
  zone_e            zone_c;
  logic [PIX_W-1:0] idx_c;
  logic [3:0]       hclk_c;
  logic             rg_c;
  logic             readout_c;

  hrt_phase_cnt #(.LINE_LEN(LINE_LEN), .PIX_W(PIX_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .qtr_o (qtr),
    .pix_o (pix)
  );

  hrt_zone_dec #(
    .N_DUMMY(N_DUMMY), .N_BLK_L(N_BLK_L), .N_OVS(N_OVS),
    .N_ACT(N_ACT), .N_BLK_R(N_BLK_R), .PIX_W(PIX_W)
  ) u_zone (
    .pix_i (pix),
    .zone_o(zone_c),
    .idx_o (idx_c)
  );

  assign readout_c = (zone_c != ZN_BLANK);

  hrt_clk_gen #(.N_PH(4), .RG_QTR(0)) u_clk (
    .qtr_i    (qtr),
    .readout_i(readout_c),
    .hclk_o   (hclk_c),
    .rg_o     (rg_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hclk_o       <= CLK_IDLE;
      rg_o         <= 1'b0;
      zone_o       <= ZN_BLANK;
      idx_o        <= '0;
      blank_o      <= 1'b1;
      line_start_o <= 1'b0;
    end else if (!en_i) begin
      hclk_o       <= CLK_IDLE;
      rg_o         <= 1'b0;
      zone_o       <= ZN_BLANK;
      idx_o        <= '0;
      blank_o      <= 1'b1;
      line_start_o <= 1'b0;
    end else begin
      hclk_o       <= hclk_c;
      rg_o         <= rg_c;
      zone_o       <= zone_c;
      idx_o        <= idx_c;
      blank_o      <= !readout_c;
      line_start_o <= (pix == '0) && (qtr == 2'd0);
    end
  end

  // R7
  rg_in_readout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |-> !blank_o);
  // R7
  rg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |=> !rg_o);
  // R5
  two_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_o |-> $countones(hclk_o) == 2);
  // R6
  idle_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> hclk_o == CLK_IDLE);
  // R8
  strobe_at_dummy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> (zone_o == ZN_DUMMY && idx_o == '0));
  // R8
  line_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blank_o) |-> line_start_o);
  // R10
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (blank_o && !rg_o && !line_start_o));
  // R9
  blank_zone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o == (zone_o == ZN_BLANK));
endmodule

// File: tb/ccd_hreadout_tg_test.sv
module ccd_hreadout_tg_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [3:0]  hclk_o;
  logic        rg_o;
  logic [2:0]  zone_o;
  logic [10:0] idx_o;
  logic        blank_o;
  logic        line_start_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ccd_hreadout_tg uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i),
    .hclk_o(hclk_o), .rg_o(rg_o), .zone_o(zone_o), .idx_o(idx_o),
    .blank_o(blank_o), .line_start_o(line_start_o)
  );

  // reference model state
  int mp = 0, mq = 0;
  logic [3:0]  e_clk = 4'b0011;
  logic        e_rg = 0, e_blank = 1, e_ls = 0;
  logic [2:0]  e_zone = 0;
  int          e_idx = 0;
  bit          e_run = 0;

  task automatic ref_out(input int p, input int q);
    int z, i;
    if      (p < 8)    begin z = 1; i = p;        end
    else if (p < 10)   begin z = 2; i = p - 8;    end
    else if (p < 18)   begin z = 3; i = p - 10;   end
    else if (p < 1618) begin z = 4; i = p - 18;   end
    else if (p < 1626) begin z = 3; i = p - 1618; end
    else if (p < 1696) begin z = 2; i = p - 1626; end
    else               begin z = 0; i = p - 1696; end
    e_zone  = 3'(z);
    e_idx   = i;
    e_blank = (z == 0);
    e_rg    = (z != 0) && (q == 0);
    e_ls    = (p == 0) && (q == 0);
    for (int k = 0; k < 4; k++)
      e_clk[k] = (z == 0) ? ((k < 2) ? 1'b1 : 1'b0) : (((q - k + 4) % 4) < 2);
  endtask

  task automatic set_idle();
    e_clk = 4'b0011; e_rg = 0; e_zone = 0; e_idx = 0; e_blank = 1; e_ls = 0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // zone segment capture for line 2
  int line_no = 0;
  int seg_len[$];
  logic [2:0] prev_zone = 0;
  longint cyc = 0, last_ls = -1;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!finished) begin
      string rq;
      rq = !e_run ? "R1/R10" : "R3-zone";
      chk(zone_o == e_zone, e_run ? "R3" : "R1", zone_o, e_zone);
      chk(idx_o == 11'(e_idx), e_run ? "R4" : "R10", idx_o, e_idx);
      chk(hclk_o == e_clk, e_blank ? "R6" : "R5", hclk_o, e_clk);
      chk(rg_o == e_rg, "R7", rg_o, e_rg);
      chk(blank_o == e_blank, "R9", blank_o, e_blank);
      chk(line_start_o == e_ls, "R8", line_start_o, e_ls);
      if (rq == "") chk(0, "R1", 0, 1);

      if (line_start_o) begin
        if (last_ls >= 0 && line_no < 3)
          chk(cyc - last_ls == 8160, "R2", int'(cyc - last_ls), 8160);
        last_ls = cyc;
        line_no++;
      end
      if (line_no == 2) begin
        if (line_start_o || zone_o != prev_zone) seg_len.push_back(1);
        else seg_len[$] = seg_len[$] + 1;
      end
      prev_zone = zone_o;

      // advance model with the input the DUT will see at the next edge
      if (!rst_ni || !en_i) begin
        set_idle(); mp = 0; mq = 0; e_run = 0;
      end else begin
        ref_out(mp, mq); e_run = 1;
        mq++;
        if (mq == 4) begin mq = 0; mp = (mp == 2039) ? 0 : mp + 1; end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    int exp_seg[7] = '{32, 8, 32, 6400, 32, 280, 1376};
    wait_cyc(3);
    rst_ni = 1'b1;                // R1 idle checked by model while en low
    wait_cyc(5);
    en_i = 1'b1;                  // R8 first line starts at first enabled edge
    wait_cyc(8160 * 2 + 4000);
    // R3 / R4 segment lengths of a full line (master cycles)
    chk(seg_len.size() == 7, "R3", seg_len.size(), 7);
    for (int s = 0; s < 7 && s < seg_len.size(); s++)
      chk(seg_len[s] == exp_seg[s], "R3", seg_len[s], exp_seg[s]);
    en_i = 1'b0;                  // R10 mid-line disable
    wait_cyc(10);
    chk(blank_o && !rg_o && hclk_o == 4'b0011, "R10", blank_o, 1);
    en_i = 1'b1;                  // R10 restart from pixel 0
    wait_cyc(9000);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(100000 * 20);
    finished = 1;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end
endmodule